// File: doc/BRIEF.md
# I2C Serial EEPROM Target (1 Kbit)

This block is an I2C target that behaves like a small serial EEPROM of 128 bytes. A fast system clock samples the bus lines SCL and SDA, and the block detects START and STOP conditions from the sampled lines. A master selects the device with a select byte. The select byte carries the fixed type code 1010, three bits that must match the pin-strapped `chip_en` inputs, and a direction flag. The block answers with an acknowledge when the select byte matches. It then accepts a word address and stores the data bytes that follow, or it returns bytes from the current address in sequence.

Each STOP that ends a write with at least one data byte starts a programming period. While this period runs, the block refuses every select byte, so a master can poll until the device answers again. The period is `PROG_CYCLES` system clocks long. It doubles when the written bytes did not all fall in one 8-byte row. The SDA pin is modelled as an open-drain pull-down enable. The system clock must run at least 20 times faster than SCL.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The block acknowledges a select byte only when its bits 7..4 equal 1010. Any other type code leaves SDA released during the ninth clock.
- R2: Bits 3..1 of the select byte must equal `chip_en[2:0]` for an acknowledge.
- R3: On a match, the block drives SDA low (`sda_oe`=1) during the ninth SCL pulse of the select byte. It also drives SDA low during the ninth pulse of every byte it receives after that select byte.
- R4: In a write (select bit 0 = 0), the first byte after the select byte sets the word address from its low 7 bits. Each following byte is stored at the current address, and the address then increments.
- R5: The word address wraps from 127 to 0, in both writing and reading.
- R6: In a read (select bit 0 = 1), the block sends bytes MSB first, starting at the current address and incrementing after each byte. When the master answers a byte with a NACK (SDA high in the ninth clock), the block releases SDA and sends no more data.
- R7: The block evaluates the select byte again after every START, including a repeated START. A write of the word address followed by a repeated START and a read select therefore reads from that address.
- R8: A STOP that ends a write with at least one data byte starts a busy period of `PROG_CYCLES` clocks. The block acknowledges no select byte while the busy period runs.
- R9: When the data bytes of one write fall in more than one 8-byte row (address bits 6..3 differ), the busy period lasts `2*PROG_CYCLES` clocks.
- R10: `sda_oe` only asserts while the sampled SCL is low, so the block never creates a false START or STOP.
- R11: After reset, `sda_oe` is 0 and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| chip_en | input | 3 | Pin-strapped device address bits, compared with select bits 3..1 |
| sda_oe | output | 1 | Pull SDA low when 1; release SDA when 0 |

## Verification
The hardest case to reach from the ports is the doubled busy period. It appears only after one write has stored bytes in two rows, and it can only be seen through the select acknowledge at a time between one and two programming periods after the STOP. The bench writes three bytes starting at address 126, so the address wraps to 0 and the bytes land in two rows. It then waits one programming period and issues a select byte, which must still be refused because the acknowledge decision falls inside the doubled period. A further wait of two periods must bring the acknowledge back. A write that stays in one row serves as the contrast case.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_eeprom_bus_sync.sv
module i2c_eeprom_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_ff[SYNC_STAGES-1];
  assign sda_s    = sda_ff[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_eeprom_store.sv
module i2c_eeprom_store #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_eeprom_prog_timer.sv
module i2c_eeprom_prog_timer #(
  parameter int PROG_CYCLES = 1000,
  localparam int CNT_W = $clog2(2 * PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic long_wr,
  output logic busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (go) cnt <= long_wr ? CNT_W'(2 * PROG_CYCLES) : CNT_W'(PROG_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_PROG_START: assert property (@(posedge clk) disable iff (rst)
    go |=> busy); // R8
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_eeprom_pkg::*;
#(
  parameter int MEM_DEPTH   = 128,
  parameter int ROW_BYTES   = 8,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_en,
  output logic       sda_oe
);
  localparam int ADDR_W  = $clog2(MEM_DEPTH);
  localparam int ROW_W   = $clog2(ROW_BYTES);
  localparam int ROWID_W = ADDR_W - ROW_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  tgt_state_e state, after;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, out_sr, rd_data;
  logic [ADDR_W-1:0] ptr;
  logic [ROWID_W-1:0] first_row;
  logic wr_any, span, busy;
  logic mem_we, prog_go, byte_done, sel_ok;

  i2c_eeprom_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  i2c_eeprom_store #(.DEPTH(MEM_DEPTH)) u_store (
    .clk(clk), .we(mem_we), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(rd_data));

  i2c_eeprom_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .go(prog_go), .long_wr(span), .busy(busy));

  always_comb begin
    byte_done = scl_fall && (bitcnt == 4'd8);
    sel_ok    = (shreg[7:4] == 4'b1010) && (shreg[3:1] == chip_en) && !busy;
    mem_we    = !stop_ev && !start_ev && (state == ST_WR) && byte_done;
    prog_go   = stop_ev && wr_any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      after     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      out_sr    <= '0;
      ptr       <= '0;
      first_row <= '0;
      wr_any    <= 1'b0;
      span      <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      wr_any <= 1'b0;
      span   <= 1'b0;
    end else if (start_ev) begin
      state  <= ST_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            bitcnt <= '0;
            if (state == ST_DEV) begin
              if (sel_ok) begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                after  <= shreg[0] ? ST_RD : ST_ADDR;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= ST_ACK;
              after  <= ST_WR;
              if (state == ST_ADDR) begin
                ptr <= shreg[ADDR_W-1:0];
              end else begin
                ptr    <= ptr + 1'b1;
                wr_any <= 1'b1;
                if (!wr_any) first_row <= ptr[ADDR_W-1:ROW_W];
                else if (ptr[ADDR_W-1:ROW_W] != first_row) span <= 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state  <= after;
            bitcnt <= '0;
            if (after == ST_RD) begin
              out_sr <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
              ptr    <= ptr + 1'b1;
            end else begin
              out_sr <= {out_sr[6:0], 1'b0};
              sda_oe <= ~out_sr[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && sda_s) begin
            state <= ST_IDLE;
          end else if (scl_fall) begin
            out_sr <= rd_data;
            sda_oe <= ~rd_data[7];
            bitcnt <= '0;
            state  <= ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

  AST_SEL_TYPE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && $past(state) == ST_DEV) |-> ($past(shreg[7:4]) == 4'b1010)); // R1
  AST_SEL_PINS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && $past(state) == ST_DEV) |-> ($past(shreg[3:1]) == $past(chip_en))); // R2
  AST_NO_SEL_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && $past(state) == ST_DEV) |-> !$past(busy)); // R8
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (!sda_oe && state == ST_IDLE)); // R6
endmodule

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;
  localparam int PROG = 1500;
  localparam int Q    = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic [2:0] chip_en = 3'b101;
  logic sda_oe;
  logic sda_line;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  assign sda_line = msda & ~sda_oe;

  always #5 clk = ~clk;

  i2c_eeprom_target #(.PROG_CYCLES(PROG)) u_i2c_eeprom_target (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .chip_en(chip_en), .sda_oe(sda_oe));

  // {expected ack, select byte}; chip_en = 101, so 8'hAA matches
  localparam logic [8:0] SEL_TAB [7] = '{
    {1'b1, 8'hAA}, {1'b0, 8'hBA}, {1'b0, 8'h2A}, {1'b0, 8'hA2},
    {1'b0, 8'hAE}, {1'b0, 8'hA8}, {1'b1, 8'hAA}};

  task automatic wq(input int n = 1);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    msda = 1'b1; wq(); scl = 1'b1; wq(); msda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    msda = 1'b0; wq(); scl = 1'b1; wq(); msda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
    end
    msda = 1'b1; wq(); scl = 1'b1; wq();
    ack = ~sda_line;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      msda = 1'b1; wq(); scl = 1'b1; wq();
      d[i] = sda_line;
      wq(); scl = 1'b0; wq();
    end
    msda = ~give_ack; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    wq(4);
    chk("R11 sda_oe after reset", int'(sda_oe), 0);

    // table walk: select decode
    for (int k = 0; k < 7; k++) begin
      i2c_start();
      send_byte(SEL_TAB[k][7:0], ack);
      chk($sformatf("R1 R2 R3 select %0h", SEL_TAB[k][7:0]), int'(ack), int'(SEL_TAB[k][8]));
      i2c_stop();
      wq(2);
    end

    // write within one row at 0x10
    i2c_start();
    send_byte(8'hAA, ack); chk("R3 write select ack", int'(ack), 1);
    send_byte(8'h10, ack); chk("R3 R4 address ack", int'(ack), 1);
    send_byte(8'h11, ack); chk("R3 R4 data ack", int'(ack), 1);
    send_byte(8'h22, ack);
    send_byte(8'h33, ack);
    i2c_stop();
    i2c_start();
    send_byte(8'hAA, ack); chk("R8 poll during busy", int'(ack), 0);
    i2c_stop();
    repeat (PROG) @(posedge clk);
    #1;
    i2c_start();
    send_byte(8'hAA, ack); chk("R8 poll after busy", int'(ack), 1);
    i2c_stop();
    wq(2);

    // random read with repeated START
    i2c_start();
    send_byte(8'hAA, ack);
    send_byte(8'h10, ack);
    i2c_start();
    send_byte(8'hAB, ack); chk("R7 read select after repeated START", int'(ack), 1);
    recv_byte(1'b1, d); chk("R4 R6 byte 0", int'(d), 8'h11);
    recv_byte(1'b1, d); chk("R6 byte 1", int'(d), 8'h22);
    recv_byte(1'b0, d); chk("R6 byte 2", int'(d), 8'h33);
    wq();
    chk("R6 released after NACK", int'(sda_oe), 0);
    i2c_stop();
    wq(2);

    // write spanning rows across the wrap point
    i2c_start();
    send_byte(8'hAA, ack);
    send_byte(8'h7E, ack);
    send_byte(8'hA1, ack);
    send_byte(8'hA2, ack);
    send_byte(8'hA3, ack); chk("R5 data ack after wrap", int'(ack), 1);
    i2c_stop();
    repeat (PROG) @(posedge clk);
    #1;
    i2c_start();
    send_byte(8'hAA, ack); chk("R9 still busy in doubled window", int'(ack), 0);
    i2c_stop();
    repeat (2 * PROG) @(posedge clk);
    #1;
    i2c_start();
    send_byte(8'hAA, ack); chk("R9 ack after doubled window", int'(ack), 1);
    i2c_stop();
    wq(2);

    // read back across the wrap
    i2c_start();
    send_byte(8'hAA, ack);
    send_byte(8'h7E, ack);
    i2c_start();
    send_byte(8'hAB, ack);
    recv_byte(1'b1, d); chk("R5 read 0x7E", int'(d), 8'hA1);
    recv_byte(1'b1, d); chk("R5 read 0x7F", int'(d), 8'hA2);
    recv_byte(1'b0, d); chk("R5 read 0x00", int'(d), 8'hA3);
    i2c_stop();
    wq(2);
    chk("R10 idle bus released", int'(sda_oe), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule